// File: doc/BRIEF.md
# Pulse-Swallow Loop Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It runs on the fast oscillator-rate clock and divides it by a programmable integer. Once per division period it emits a single-cycle pulse that a phase comparator outside the block can use.

Inside, a two-ratio prescaler divides by 7 or by 6. A 4-bit swallow counter decides how many prescaler rounds in each period use the longer ratio. A 6-bit main counter sets how many prescaler rounds make up one period. A scale bit doubles both prescaler ratios, to 14 and 12.

The swallow value, the main value and the scale bit are taken in only at the point where the period restarts. A debug output reports the ratio that the prescaler is currently using.

Top module: `swdiv_fb`

## Requirements
- R1: With swallow value A in 1..M+1 and scale bit 0, consecutive output pulses are exactly 6·(M+1)+A clock cycles apart, where M is the 6-bit main value.
- R2: With A = 0, the period is 7·(M+1) cycles and the debug modulus reads 7 (14 when doubled) for the whole period.
- R3: When A exceeds M+1, the block behaves as if A = M+1, giving a period of 7·(M+1), or twice that when doubled.
- R4: With the scale bit at 1, the prescaler ratios become 14 and 12, so every period of R1 to R3 is doubled. The debug modulus reads 14 for the first A·14 cycles and 12 afterwards.
- R5: The output pulse is high for exactly one clock cycle per period.
- R6: A, M and the scale bit are taken in only at the cycle where a period ends. A change made during a period, whether kept or withdrawn before the period ends, leaves that period's length unchanged.
- R7: The debug modulus output is an unsigned integer equal to the ratio in use. With A nonzero it reads 7 on the cycle after the pulse and for the first A·7 cycles, then reads 6 until the next pulse.
- R8: While reset is held, the pulse output is 0 and the debug modulus reads 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| swallow_cnt_i | input | 4 | Number of long-ratio prescaler rounds per period (A) |
| main_cnt_i | input | 6 | Main counter value; rounds per period = value + 1 (M) |
| dbl_i | input | 1 | Doubles both prescaler ratios when 1 |
| fb_pulse_o | output | 1 | One-cycle pulse at the end of every division period |
| pre_mod_o | output | 4 | Prescaler ratio currently in use (6, 7, 12 or 14) |

## Verification
Internal faults show up at the ports in two ways. A wrong main or swallow count changes the spacing between pulses, and the error is visible when the next pulse arrives, no more than about 900 cycles later. A swallow counter that runs down at the wrong time moves the point where the debug modulus steps from the long ratio to the short one, and that shows within the same period. A configuration register that loads outside the period end shows up as a wrong length in the period where the stimulus changed.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

   typedef enum logic [0:0] {
      SCALE_X1 = 1'b0,
      SCALE_X2 = 1'b1
   } scale_e;

   function automatic int unsigned bits_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/swdiv_cfg.sv
module swdiv_cfg #(
   parameter int unsigned A_W = 4,
   parameter int unsigned M_W = 6
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           reload,
   input  logic [A_W-1:0] a_in,
   input  logic [M_W-1:0] m_in,
   input  logic           dbl_in,
   output logic [A_W-1:0] a_q,
   output logic [M_W-1:0] m_q,
   output logic           dbl_q,
   output logic [A_W-1:0] a_clamp,
   output logic           zero_a_nxt,
   output logic           dbl_nxt
);
   localparam int unsigned CW = (A_W > M_W + 1) ? A_W : M_W + 1;

   logic [CW-1:0] a_wide;
   logic [CW-1:0] a_limit;

   always_comb begin
      a_wide  = CW'(a_in);
      a_limit = CW'(m_in) + CW'(1);
      if (a_wide > a_limit) a_clamp = A_W'(a_limit);
      else                  a_clamp = a_in;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q   <= '0;
         m_q   <= '0;
         dbl_q <= 1'b0;
      end else if (reload) begin
         a_q   <= a_clamp;
         m_q   <= m_in;
         dbl_q <= dbl_in;
      end
   end

   assign zero_a_nxt = reload ? (a_clamp == '0) : (a_q == '0);
   assign dbl_nxt    = reload ? dbl_in : dbl_q;

endmodule

// File: rtl/swdiv_swallow.sv
module swdiv_swallow #(
   parameter int unsigned A_W = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           reload,
   input  logic           term,
   input  logic [A_W-1:0] a_load,
   output logic [A_W-1:0] a_left_nxt
);
   logic [A_W-1:0] a_left;

   always_comb begin
      a_left_nxt = a_left;
      if (reload)                    a_left_nxt = a_load;
      else if (term && a_left != '0) a_left_nxt = a_left - A_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) a_left <= '0;
      else     a_left <= a_left_nxt;
   end

endmodule

// File: rtl/swdiv_main.sv
module swdiv_main #(
   parameter int unsigned M_W = 6
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           reload,
   input  logic           term,
   input  logic [M_W-1:0] m_load,
   output logic           m_zero
);
   logic [M_W-1:0] m_left;

   always_ff @(posedge clk) begin
      if (rst)         m_left <= '0;
      else if (reload) m_left <= m_load;
      else if (term)   m_left <= m_left - M_W'(1);
   end

   assign m_zero = (m_left == '0);

endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
   parameter int unsigned LO_MOD = 6,
   parameter bit          DBL_EN = 1'b1,
   parameter int unsigned MOD_W  = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sel_hi_nxt,
   input  logic             dbl_nxt,
   output logic             term,
   output logic [MOD_W-1:0] cur_mod
);
   localparam logic [MOD_W-1:0] LO_V = MOD_W'(LO_MOD);
   localparam logic [MOD_W-1:0] HI_V = MOD_W'(LO_MOD + 1);

   logic [MOD_W-1:0] base_mod;
   logic [MOD_W-1:0] mod_nxt;
   logic [MOD_W-1:0] pre_cnt;

   assign base_mod = sel_hi_nxt ? HI_V : LO_V;

   generate
      if (DBL_EN) begin : g_scaled
         assign mod_nxt = dbl_nxt ? (base_mod << 1) : base_mod;
      end else begin : g_fixed
         logic unused_dbl;
         assign unused_dbl = dbl_nxt;
         assign mod_nxt    = base_mod;
      end
   endgenerate

   assign term = (pre_cnt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         pre_cnt <= '0;
         cur_mod <= HI_V;
      end else if (term) begin
         pre_cnt <= mod_nxt - MOD_W'(1);
         cur_mod <= mod_nxt;
      end else begin
         pre_cnt <= pre_cnt - MOD_W'(1);
      end
   end

endmodule

// File: rtl/swdiv_fb.sv
module swdiv_fb #(
   parameter int unsigned A_W    = 4,
   parameter int unsigned M_W    = 6,
   parameter int unsigned LO_MOD = 6,
   parameter bit          DBL_EN = 1'b1,
   parameter int unsigned MOD_W  = swdiv_pkg::bits_for(2 * (LO_MOD + 1))
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [A_W-1:0]   swallow_cnt_i,
   input  logic [M_W-1:0]   main_cnt_i,
   input  logic             dbl_i,
   output logic             fb_pulse_o,
   output logic [MOD_W-1:0] pre_mod_o
);
   localparam int unsigned TOP_MOD = DBL_EN ? 2 * (LO_MOD + 1) : LO_MOD + 1;

   generate
      if (LO_MOD < 2) begin : g_bad_mod
         $error("swdiv_fb: LO_MOD must be at least 2");
      end
      if (swdiv_pkg::bits_for(TOP_MOD) > MOD_W) begin : g_bad_w
         $error("swdiv_fb: MOD_W too narrow for the largest ratio");
      end
      if (A_W < 1 || M_W < 1) begin : g_bad_cnt
         $error("swdiv_fb: counter widths must be positive");
      end
   endgenerate

   logic           term;
   logic           m_zero;
   logic           reload;
   logic           armed;
   logic [A_W-1:0] a_q;
   logic [M_W-1:0] m_q;
   logic           dbl_q;
   logic [A_W-1:0] a_clamp;
   logic           zero_a_nxt;
   logic           dbl_nxt;
   logic [A_W-1:0] a_left_nxt;
   logic           sel_hi_nxt;

   assign reload     = term && m_zero;
   assign sel_hi_nxt = zero_a_nxt || (a_left_nxt != '0);

   swdiv_cfg #(.A_W(A_W), .M_W(M_W)) u_cfg (
      .clk        (clk),
      .rst        (rst),
      .reload     (reload),
      .a_in       (swallow_cnt_i),
      .m_in       (main_cnt_i),
      .dbl_in     (dbl_i),
      .a_q        (a_q),
      .m_q        (m_q),
      .dbl_q      (dbl_q),
      .a_clamp    (a_clamp),
      .zero_a_nxt (zero_a_nxt),
      .dbl_nxt    (dbl_nxt)
   );

   swdiv_swallow #(.A_W(A_W)) u_swallow (
      .clk        (clk),
      .rst        (rst),
      .reload     (reload),
      .term       (term),
      .a_load     (a_clamp),
      .a_left_nxt (a_left_nxt)
   );

   swdiv_main #(.M_W(M_W)) u_main (
      .clk    (clk),
      .rst    (rst),
      .reload (reload),
      .term   (term),
      .m_load (main_cnt_i),
      .m_zero (m_zero)
   );

   swdiv_prescaler #(.LO_MOD(LO_MOD), .DBL_EN(DBL_EN), .MOD_W(MOD_W)) u_pre (
      .clk        (clk),
      .rst        (rst),
      .sel_hi_nxt (sel_hi_nxt),
      .dbl_nxt    (dbl_nxt),
      .term       (term),
      .cur_mod    (pre_mod_o)
   );

   // The first reload after reset only primes the counters and emits no pulse.
   always_ff @(posedge clk) begin
      if (rst) begin
         armed      <= 1'b0;
         fb_pulse_o <= 1'b0;
      end else begin
         armed      <= 1'b1;
         fb_pulse_o <= reload && armed;
      end
   end

endmodule

// File: rtl/swdiv_fb_chk.sv
module swdiv_fb_chk #(
   parameter int unsigned A_W    = 4,
   parameter int unsigned M_W    = 6,
   parameter int unsigned LO_MOD = 6,
   parameter int unsigned MOD_W  = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             fb_pulse_o,
   input logic [MOD_W-1:0] pre_mod_o,
   input logic             reload,
   input logic [A_W-1:0]   a_q,
   input logic [M_W-1:0]   m_q,
   input logic             dbl_q
);
   localparam logic [MOD_W-1:0] LO1 = MOD_W'(LO_MOD);
   localparam logic [MOD_W-1:0] HI1 = MOD_W'(LO_MOD + 1);
   localparam logic [MOD_W-1:0] LO2 = MOD_W'(2 * LO_MOD);
   localparam logic [MOD_W-1:0] HI2 = MOD_W'(2 * (LO_MOD + 1));

   logic mod_low;
   assign mod_low = (pre_mod_o == LO1) || (pre_mod_o == LO2);

   // R5: the pulse lasts one cycle
   a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
      fb_pulse_o |=> !fb_pulse_o);

   // R5: a pulse only follows a period end
   a_r5_after_reload: assert property (@(posedge clk) disable iff (rst)
      $rose(fb_pulse_o) |-> $past(reload));

   // R6: configuration is held between period ends
   a_r6_hold_cfg: assert property (@(posedge clk) disable iff (rst)
      !reload |=> ($stable(a_q) && $stable(m_q) && $stable(dbl_q)));

   // R3: the stored swallow value never exceeds M+1
   a_r3_clamp: assert property (@(posedge clk) disable iff (rst)
      int'(a_q) <= int'(m_q) + 1);

   // R4: the ratio in use matches the scale setting
   a_r4_mod_legal: assert property (@(posedge clk) disable iff (rst)
      dbl_q ? (pre_mod_o == LO2 || pre_mod_o == HI2)
            : (pre_mod_o == LO1 || pre_mod_o == HI1));

   // R2: zero swallow keeps the long ratio all period
   a_r2_zero_long: assert property (@(posedge clk) disable iff (rst)
      (a_q == '0) |-> (pre_mod_o == (dbl_q ? HI2 : HI1)));

   // R7: once short, the ratio stays short until the period ends
   a_r7_no_return: assert property (@(posedge clk) disable iff (rst)
      (mod_low && !reload) |=> mod_low);

endmodule

bind swdiv_fb swdiv_fb_chk #(
   .A_W(A_W), .M_W(M_W), .LO_MOD(LO_MOD), .MOD_W(MOD_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .fb_pulse_o (fb_pulse_o),
   .pre_mod_o  (pre_mod_o),
   .reload     (reload),
   .a_q        (a_q),
   .m_q        (m_q),
   .dbl_q      (dbl_q)
);

// File: tb/tb_swdiv_fb.sv
module tb_swdiv_fb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] a_in = '0;
   logic [5:0] m_in = '0;
   logic       dbl = 1'b0;
   logic       pulse;
   logic [3:0] pmod;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   swdiv_fb dut (
      .clk           (clk),
      .rst           (rst),
      .swallow_cnt_i (a_in),
      .main_cnt_i    (m_in),
      .dbl_i         (dbl),
      .fb_pulse_o    (pulse),
      .pre_mod_o     (pmod)
   );

   localparam int NV = 9;
   localparam int VA [NV] = '{0, 3, 0, 15, 5, 1, 4, 0, 9};
   localparam int VM [NV] = '{0, 9, 9, 63, 2, 0, 7, 3, 0};
   localparam int VD [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1};
   localparam int VN [NV] = '{7, 63, 70, 399, 21, 7, 104, 56, 14};
   localparam string VR [NV] = '{"R2", "R1", "R2", "R1", "R3", "R1", "R4", "R4", "R3"};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic wait_pulse();
      do @(negedge clk); while (!pulse);
   endtask

   // Called at the negedge where the pulse is visible; counts to the next pulse.
   task automatic measure(input int probe_k, output int n, output int probe_mod);
      int k = 0;
      probe_mod = -1;
      forever begin
         @(negedge clk);
         k++;
         if (k == 1) check(pulse == 1'b0, "R5", int'(pulse), 0);
         if (k == probe_k) probe_mod = int'(pmod);
         if (pulse) break;
      end
      n = k;
   endtask

   initial begin
      int n;
      int pm;
      // R8: reset state
      repeat (4) @(negedge clk);
      check(pulse == 1'b0, "R8", int'(pulse), 0);
      check(pmod == 4'd7, "R8", int'(pmod), 7);
      rst = 1'b0;

      // table of settings and expected periods
      for (int i = 0; i < NV; i++) begin
         a_in = VA[i][3:0];
         m_in = VM[i][5:0];
         dbl  = VD[i][0];
         wait_pulse();
         measure(0, n, pm);
         check(n == VN[i], VR[i], n, VN[i]);
      end

      // R7: long ratio for first A rounds, then short
      a_in = 4'd3; m_in = 6'd9; dbl = 1'b0;
      wait_pulse();
      measure(20, n, pm);
      check(pm == 7, "R7", pm, 7);
      measure(21, n, pm);
      check(pm == 6, "R7", pm, 6);
      check(n == 63, "R1", n, 63);

      // R2: zero swallow stays long to the end of the period
      a_in = 4'd0;
      wait_pulse();
      measure(69, n, pm);
      check(pm == 7, "R2", pm, 7);

      // R4: doubled ratios step from 14 to 12 after A*14 cycles
      a_in = 4'd4; m_in = 6'd7; dbl = 1'b1;
      wait_pulse();
      measure(55, n, pm);
      check(pm == 14, "R4", pm, 14);
      measure(56, n, pm);
      check(pm == 12, "R4", pm, 12);

      // R6: a change withdrawn mid-period has no effect
      a_in = 4'd3; m_in = 6'd9; dbl = 1'b0;
      wait_pulse();
      begin
         int k = 0;
         forever begin
            @(negedge clk);
            k++;
            if (k == 5)  begin a_in = 4'd0; m_in = 6'd1; dbl = 1'b1; end
            if (k == 30) begin a_in = 4'd3; m_in = 6'd9; dbl = 1'b0; end
            if (pulse) break;
         end
         check(k == 63, "R6", k, 63);
      end

      // R6: a kept change only takes effect in the following period
      a_in = 4'd0; m_in = 6'd0;
      measure(0, n, pm);
      check(n == 63, "R6", n, 63);
      measure(0, n, pm);
      check(n == 7, "R6", n, 7);

      // R8: reset again mid-period
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(pulse == 1'b0, "R8", int'(pulse), 0);
      check(pmod == 4'd7, "R8", int'(pmod), 7);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule